// File: doc/BRIEF.md
# SD Host Command Issue Unit

This block is the register-mapped command front end of an SD/MMC host controller. Software loads a 32-bit argument and then writes a 16-bit command word; that write launches a request toward a line engine, which serialises the command on the card's CMD line and returns either a response frame, a timeout or, for data commands, a transfer-done pulse. The line engine is modelled as a level request with an acknowledge pulse, followed by a response-valid pulse carrying the received frame.

The unit decodes the command word: a six-bit command index, a two-bit response kind, and flags for data present, index check and CRC check. It tracks two inhibit flags in a present-state word. The CMD inhibit covers the command in flight. The DAT inhibit covers a data transfer or a busy period signalled on DAT0. Command writes that would break the inhibit rules are dropped and leave a sticky error flag. Received responses go into four 32-bit response words. A long response is stored with its trailing CRC byte removed, so the payload sits eight bits lower.

Top module: `sd_cmd_issue`

## Requirements
- R1: After reset the present-state word, the argument and command registers, all four response words, `eng_req` and `cmd_drop_err` are zero.
- R2: A command write that is accepted sets CMD inhibit (present-state bit 0) and `eng_req` on the next edge. The request presents the command index from command bits 13:8, the argument, the response kind from bits 1:0, data-present from bit 5, index-check from bit 4 and CRC-check from bit 3. `eng_req` stays high until the edge at which `eng_ack` is sampled.
- R3: On an accepted command, DAT inhibit (present-state bit 1) is set when data-present is 1 or the response kind is 11 (48-bit response with busy). Response kinds are 00 none, 01 136-bit, 10 48-bit, 11 48-bit with busy.
- R4: A command write is dropped while CMD inhibit is set. A write of kind 11 without data is also dropped while DAT inhibit is set. Other commands ignore DAT inhibit. A dropped write leaves the command register (address 1) and the request unchanged, and sets the sticky `cmd_drop_err`, also read at address 3 bit 0.
- R5: For response kind 00, CMD inhibit reads 1 after the edge that samples `eng_ack` and reads 0 after the following edge.
- R6: For kinds 10 and 11, the edge that samples `eng_rsp_valid` clears CMD inhibit and loads response word 0 (address 4) with frame bits 39:8. Words 1 to 3 keep their values.
- R7: For kind 01, the same edge loads the frame shifted right by 8 bits across words 0 to 3 (addresses 4 to 7): word k holds frame bits 32k+39:32k+8, and the top byte of word 3 is zero.
- R8: For kind 11 without data, DAT inhibit stays set after the response until an edge samples `dat_lvl[0]` high, and it clears at that edge.
- R9: For a command with data present, DAT inhibit clears at the edge that samples `eng_xfer_done`.
- R10: `eng_timeout` during a command clears CMD inhibit and `eng_req`. It clears DAT inhibit only if that command set it. The response words are left unchanged.
- R11: Present-state bits 23:20 show `dat_lvl[3:0]` with no delay, DAT0 in bit 20.
- R12: Writes to the argument register (address 0) are always taken and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 argument, 1 command |
| wr_data | input | 32 | Write data; command uses bits 15:0 |
| rd_addr | input | 3 | Read address: 0 arg, 1 cmd, 2 present state, 3 error, 4-7 response words |
| rd_data | output | 32 | Read data, combinational |
| eng_req | output | 1 | Command request to the line engine |
| eng_idx | output | 6 | Command index |
| eng_arg | output | 32 | Command argument |
| eng_kind | output | 2 | Response kind |
| eng_data | output | 1 | Data transfer follows |
| eng_idx_chk | output | 1 | Check response index |
| eng_crc_chk | output | 1 | Check response CRC |
| eng_ack | input | 1 | Engine took the command (pulse) |
| eng_rsp_valid | input | 1 | Response frame valid (pulse) |
| eng_rsp | input | 128 | Response frame, last received bit in bit 0 |
| eng_timeout | input | 1 | Command timed out (pulse) |
| eng_xfer_done | input | 1 | Data transfer finished (pulse) |
| dat_lvl | input | 4 | Current DAT[3:0] line levels |
| cmd_drop_err | output | 1 | Sticky flag for a dropped command write |

## Verification
The bench targets four corner cases. The first is the no-response command: a design that clears CMD inhibit on the acknowledge edge itself, or waits for a response that never comes, fails the two-step check of R5. The second is a busy command followed by an ordinary one. A design that applies DAT inhibit to every command would drop the second write. One that ignores DAT inhibit would accept a second busy command, and the command register readback shows either fault. Long responses are compared word by word against a shift computed in the bench, which exposes a missing CRC strip or a wrong word order. A timeout that clears the wrong inhibit, or that overwrites the response words, shows up in the present-state word and the response readback.

// File: rtl/sdc_pkg.sv
// Shared types and register map for the SD command issue unit.
// Assumes a 16-bit command word with fixed field positions.
package sdc_pkg;
    typedef enum logic [1:0] {
        RSP_NONE       = 2'b00,
        RSP_LONG       = 2'b01,
        RSP_SHORT      = 2'b10,
        RSP_SHORT_BUSY = 2'b11
    } rsp_kind_e;

    typedef struct packed {
        logic [5:0] idx;
        logic       data;
        logic       idx_chk;
        logic       crc_chk;
        rsp_kind_e  kind;
    } cmd_fields_t;

    localparam int unsigned REG_ARG  = 0;
    localparam int unsigned REG_CMD  = 1;
    localparam int unsigned REG_PRES = 2;
    localparam int unsigned REG_ERR  = 3;
    localparam int unsigned REG_RSP0 = 4;
    localparam int unsigned PRES_DAT_LSB = 20;
endpackage

// File: rtl/sdc_cmd_decode.sv
// Splits a command word into its fields and derives the DAT-inhibit needs.
// Assumes: index 13:8, data 5, index check 4, CRC check 3, kind 1:0.
module sdc_cmd_decode
    import sdc_pkg::*;
(
    input  logic [15:0]  cmd_word,
    output cmd_fields_t  f,
    output logic         wants_dat,
    output logic         busy_only
);
    logic unused_bits;

    // Field extraction and derived flags.
    always_comb begin
        f.idx     = cmd_word[13:8];
        f.data    = cmd_word[5];
        f.idx_chk = cmd_word[4];
        f.crc_chk = cmd_word[3];
        f.kind    = rsp_kind_e'(cmd_word[1:0]);
        wants_dat = f.data || (f.kind == RSP_SHORT_BUSY);
        busy_only = !f.data && (f.kind == RSP_SHORT_BUSY);
    end

    assign unused_bits = ^{cmd_word[15:14], cmd_word[7:6], cmd_word[2]};
endmodule

// File: rtl/sdc_inhibit_ctl.sv
// Tracks CMD and DAT inhibit, the engine request and the dropped-write flag.
// Assumes the engine acknowledges before it returns a response, and that a
// response and a timeout never arrive in the same cycle.
module sdc_inhibit_ctl
    import sdc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  cmd_fields_t new_f,
    input  logic        new_wants_dat,
    input  logic        new_busy_only,
    input  cmd_fields_t cur_f,
    input  logic        eng_ack,
    input  logic        eng_rsp_valid,
    input  logic        eng_timeout,
    input  logic        eng_xfer_done,
    input  logic        dat0,
    output logic        accept,
    output logic        rsp_take,
    output logic        cmd_inh,
    output logic        dat_inh,
    output logic        req,
    output logic        drop_err
);
    logic nr_pend;   // no-response command acknowledged, clear next cycle
    logic dat_cur;   // the command in flight owns DAT inhibit
    logic dmode;     // DAT owner is a data transfer
    logic bmode;     // DAT owner is a busy-only command
    logic bwait;     // waiting for DAT0 to go high after a busy response
    logic ack_none;

    // Acceptance: CMD inhibit blocks all, DAT inhibit blocks busy-only.
    assign accept   = cmd_wr && !cmd_inh && !(new_busy_only && dat_inh);
    assign rsp_take = eng_rsp_valid && cmd_inh && !req && !eng_timeout
                      && (cur_f.kind != RSP_NONE);
    assign ack_none = eng_ack && req && (cur_f.kind == RSP_NONE);

    // Command side: inhibit, request and no-response completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_inh <= 1'b0;
            req     <= 1'b0;
            nr_pend <= 1'b0;
        end else if (accept) begin
            cmd_inh <= 1'b1;
            req     <= 1'b1;
            nr_pend <= 1'b0;
        end else if (eng_timeout && cmd_inh) begin
            cmd_inh <= 1'b0;
            req     <= 1'b0;
            nr_pend <= 1'b0;
        end else begin
            if (req && eng_ack) begin
                req     <= 1'b0;
                nr_pend <= (cur_f.kind == RSP_NONE);
            end
            if (nr_pend) begin
                cmd_inh <= 1'b0;
                nr_pend <= 1'b0;
            end
            if (rsp_take) cmd_inh <= 1'b0;
        end
    end

    // Data side: DAT inhibit ownership, busy wait and transfer completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_inh <= 1'b0;
            dat_cur <= 1'b0;
            dmode   <= 1'b0;
            bmode   <= 1'b0;
            bwait   <= 1'b0;
        end else if (accept) begin
            dat_cur <= new_wants_dat;
            if (new_wants_dat) begin
                dat_inh <= 1'b1;
                dmode   <= new_f.data;
                bmode   <= new_busy_only;
                bwait   <= 1'b0;
            end
        end else if (eng_timeout && cmd_inh) begin
            if (dat_cur) begin
                dat_inh <= 1'b0;
                bwait   <= 1'b0;
            end
            dat_cur <= 1'b0;
        end else begin
            if (rsp_take && dat_cur && bmode) bwait <= 1'b1;
            if (bwait && dat0) begin
                dat_inh <= 1'b0;
                bwait   <= 1'b0;
            end
            if (eng_xfer_done && dat_inh && dmode) dat_inh <= 1'b0;
        end
    end

    // Sticky record of dropped command writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                drop_err <= 1'b0;
        else if (cmd_wr && !accept) drop_err <= 1'b1;
    end

    // R2
    accept_sets_inh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (cmd_inh && req));
    // R2
    req_needs_inh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> cmd_inh);
    // R4
    dropped_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !accept) |=> drop_err);
    // R4
    drop_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_err |=> drop_err);
    // R5
    noresp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ack_none, 2) |-> !cmd_inh);
    // R5
    noresp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_none && !eng_timeout) |=> (cmd_inh && !req));
    // R9
    xfer_clears_dat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_xfer_done && dat_inh && dmode && !accept && !(eng_timeout && cmd_inh))
        |=> !dat_inh);
endmodule

// File: rtl/sdc_resp_store.sv
// Holds the response words. Loads the CRC-stripped frame into word 0 for a
// short response and into every word for a long one.
// Assumes the frame's low STRIP bits carry CRC and end bit.
module sdc_resp_store #(
    parameter int unsigned WORDS = 4,
    parameter int unsigned W     = 32,
    parameter int unsigned STRIP = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic               long_rsp,
    input  logic [WORDS*W-1:0] frame,
    output logic [WORDS*W-1:0] words
);
    localparam int unsigned FRAME_W = WORDS * W;

    logic [FRAME_W-1:0] shifted;

    assign shifted = frame >> STRIP;

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        // Load word i on a long response, or word 0 on any response.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[i*W +: W] <= '0;
            else if (take && (long_rsp || i == 0))
                words[i*W +: W] <= shifted[i*W +: W];
        end
    end
endmodule

// File: rtl/sd_cmd_issue.sv
// SD host command issue unit: argument and command registers, present-state
// word, engine request and response words.
// Assumes a single register write port and a combinational read port.
module sd_cmd_issue
    import sdc_pkg::*;
#(
    parameter int unsigned ARG_W     = 32,
    parameter int unsigned CMD_W     = 16,
    parameter int unsigned RSP_WORDS = 4,
    parameter int unsigned DAT_W     = 4,
    parameter int unsigned ADDR_W    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [ARG_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [ARG_W-1:0]           rd_data,
    output logic                       eng_req,
    output logic [5:0]                 eng_idx,
    output logic [ARG_W-1:0]           eng_arg,
    output logic [1:0]                 eng_kind,
    output logic                       eng_data,
    output logic                       eng_idx_chk,
    output logic                       eng_crc_chk,
    input  logic                       eng_ack,
    input  logic                       eng_rsp_valid,
    input  logic [RSP_WORDS*ARG_W-1:0] eng_rsp,
    input  logic                       eng_timeout,
    input  logic                       eng_xfer_done,
    input  logic [DAT_W-1:0]           dat_lvl,
    output logic                       cmd_drop_err
);
    localparam int unsigned FRAME_W = RSP_WORDS * ARG_W;

    logic [ARG_W-1:0]   arg_q;
    logic [CMD_W-1:0]   cmd_q;
    cmd_fields_t        new_f, cur_f;
    logic               new_wants, new_busy, cur_wants, cur_busy;
    logic               cmd_wr, accept, rsp_take, cmd_inh, dat_inh;
    logic [FRAME_W-1:0] rsp_words;
    logic [ARG_W-1:0]   pres;

    assign cmd_wr = wr_en && (wr_addr == ADDR_W'(REG_CMD));

    sdc_cmd_decode u_dec_new (
        .cmd_word (wr_data[CMD_W-1:0]),
        .f        (new_f),
        .wants_dat(new_wants),
        .busy_only(new_busy)
    );

    sdc_cmd_decode u_dec_cur (
        .cmd_word (cmd_q),
        .f        (cur_f),
        .wants_dat(cur_wants),
        .busy_only(cur_busy)
    );

    sdc_inhibit_ctl u_inh (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (cmd_wr),
        .new_f        (new_f),
        .new_wants_dat(new_wants),
        .new_busy_only(new_busy),
        .cur_f        (cur_f),
        .eng_ack      (eng_ack),
        .eng_rsp_valid(eng_rsp_valid),
        .eng_timeout  (eng_timeout),
        .eng_xfer_done(eng_xfer_done),
        .dat0         (dat_lvl[0]),
        .accept       (accept),
        .rsp_take     (rsp_take),
        .cmd_inh      (cmd_inh),
        .dat_inh      (dat_inh),
        .req          (eng_req),
        .drop_err     (cmd_drop_err)
    );

    sdc_resp_store #(.WORDS(RSP_WORDS), .W(ARG_W), .STRIP(8)) u_rsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (rsp_take),
        .long_rsp(cur_f.kind == RSP_LONG),
        .frame   (eng_rsp),
        .words   (rsp_words)
    );

    // Argument register: always writable.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          arg_q <= '0;
        else if (wr_en && wr_addr == ADDR_W'(REG_ARG))       arg_q <= wr_data;
    end

    // Command register: loads only when the write is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= '0;
        else if (accept) cmd_q <= wr_data[CMD_W-1:0];
    end

    // Request fields come from the held command.
    always_comb begin
        eng_idx     = cur_f.idx;
        eng_arg     = arg_q;
        eng_kind    = cur_f.kind;
        eng_data    = cur_f.data;
        eng_idx_chk = cur_f.idx_chk;
        eng_crc_chk = cur_f.crc_chk;
    end

    // Present-state word assembly.
    always_comb begin
        pres = '0;
        pres[0] = cmd_inh;
        pres[1] = dat_inh;
        pres[PRES_DAT_LSB +: DAT_W] = dat_lvl;
    end

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(REG_ARG))  rd_data = arg_q;
        if (rd_addr == ADDR_W'(REG_CMD))  rd_data = ARG_W'(cmd_q);
        if (rd_addr == ADDR_W'(REG_PRES)) rd_data = pres;
        if (rd_addr == ADDR_W'(REG_ERR))  rd_data = ARG_W'(cmd_drop_err);
        for (int i = 0; i < RSP_WORDS; i++)
            if (rd_addr == ADDR_W'(REG_RSP0 + i)) rd_data = rsp_words[i*ARG_W +: ARG_W];
    end

    // R6 R7
    rsp_clears_cmd_inh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_take |=> !cmd_inh);
    // R4
    dropped_cmd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !accept) |=> $stable(cmd_q));
    // R3
    busy_sets_dat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && new_wants) |=> dat_inh);
endmodule

// File: tb/sim_sd_cmd_issue.sv
module sim_sd_cmd_issue;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [2:0]   rd_addr = '0;
    logic [31:0]  rd_data;
    logic         eng_req;
    logic [5:0]   eng_idx;
    logic [31:0]  eng_arg;
    logic [1:0]   eng_kind;
    logic         eng_data, eng_idx_chk, eng_crc_chk;
    logic         eng_ack = 1'b0, eng_rsp_valid = 1'b0;
    logic [127:0] eng_rsp = '0;
    logic         eng_timeout = 1'b0, eng_xfer_done = 1'b0;
    logic [3:0]   dat_lvl = 4'hF;
    logic         cmd_drop_err;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] exp_rsp [4];
    logic [31:0] rv;

    always #2 clk = ~clk;

    sd_cmd_issue u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .eng_req(eng_req), .eng_idx(eng_idx), .eng_arg(eng_arg),
        .eng_kind(eng_kind), .eng_data(eng_data), .eng_idx_chk(eng_idx_chk),
        .eng_crc_chk(eng_crc_chk), .eng_ack(eng_ack),
        .eng_rsp_valid(eng_rsp_valid), .eng_rsp(eng_rsp),
        .eng_timeout(eng_timeout), .eng_xfer_done(eng_xfer_done),
        .dat_lvl(dat_lvl), .cmd_drop_err(cmd_drop_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); eng_ack = 1'b1;
        @(negedge clk); eng_ack = 1'b0;
    endtask

    task automatic pulse_rsp(input logic [127:0] fr);
        @(negedge clk); eng_rsp_valid = 1'b1; eng_rsp = fr;
        @(negedge clk); eng_rsp_valid = 1'b0;
    endtask

    task automatic pulse_tmo();
        @(negedge clk); eng_timeout = 1'b1;
        @(negedge clk); eng_timeout = 1'b0;
    endtask

    task automatic pulse_xfer();
        @(negedge clk); eng_xfer_done = 1'b1;
        @(negedge clk); eng_xfer_done = 1'b0;
    endtask

    function automatic logic [31:0] mk_cmd(input logic [5:0] idx, input logic dat,
                                           input logic ic, input logic cc,
                                           input logic [1:0] kind);
        return {18'h0, idx, 2'b00, dat, ic, cc, 1'b0, kind};
    endfunction

    // Expected response words after a response of the given kind (R6/R7).
    function automatic void model_rsp(input logic [1:0] kind, input logic [127:0] fr);
        logic [127:0] sh;
        sh = fr >> 8;
        if (kind == 2'b01) begin
            for (int k = 0; k < 4; k++) exp_rsp[k] = sh[k*32 +: 32];
        end else begin
            exp_rsp[0] = sh[31:0];
        end
    endfunction

    task automatic chk_rsp_words(input string tag);
        logic [31:0] d;
        for (int k = 0; k < 4; k++) begin
            rd(3'(4 + k), d);
            chk(tag, d, exp_rsp[k]);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd1357);
        for (int k = 0; k < 4; k++) exp_rsp[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd2, rv); chk("R1 present state", rv, 32'h00F0_0000);
        rd(3'd0, rv); chk("R1 argument", rv, 32'h0);
        rd(3'd1, rv); chk("R1 command", rv, 32'h0);
        rd(3'd3, rv); chk("R1 error", rv, 32'h0);
        chk("R1 eng_req", 32'(eng_req), 32'h0);
        chk_rsp_words("R1 response words");

        // R11 line levels, R12 argument readback
        dat_lvl = 4'h5; rd(3'd2, rv); chk("R11 dat levels", rv[23:20], 32'h5);
        dat_lvl = 4'hA; rd(3'd2, rv); chk("R11 dat levels", rv[23:20], 32'hA);
        dat_lvl = 4'hF;
        wr(3'd0, 32'hDEAD_BEEF); rd(3'd0, rv); chk("R12 argument", rv, 32'hDEAD_BEEF);

        // Random command sequences
        for (int it = 0; it < 60; it++) begin
            logic [5:0]   idx;
            logic [31:0]  arg, cw;
            logic [1:0]   kind;
            logic         dat, ic, cc;
            logic [127:0] fr;
            idx  = 6'($urandom);
            arg  = $urandom;
            kind = 2'($urandom);
            dat  = 1'($urandom);
            ic   = 1'($urandom);
            cc   = 1'($urandom);
            cw   = mk_cmd(idx, dat, ic, cc, kind);
            wr(3'd0, arg);
            rd(3'd0, rv); chk("R12 argument", rv, arg);
            wr(3'd1, cw);
            rd(3'd2, rv);
            chk("R2 cmd inhibit set", 32'(rv[0]), 32'h1);
            chk("R3 dat inhibit", 32'(rv[1]), 32'(dat || kind == 2'b11));
            chk("R2 request fields",
                {eng_req, eng_idx, eng_kind, eng_data, eng_idx_chk, eng_crc_chk},
                {1'b1, idx, kind, dat, ic, cc});
            chk("R2 request argument", eng_arg, arg);
            repeat ($urandom % 3) @(negedge clk);
            chk("R2 request held", 32'(eng_req), 32'h1);
            pulse_ack();
            chk("R2 request drops on ack", 32'(eng_req), 32'h0);
            if (kind == 2'b00) begin
                rd(3'd2, rv); chk("R5 inhibit one cycle after ack", 32'(rv[0]), 32'h1);
                @(negedge clk);
                rd(3'd2, rv); chk("R5 inhibit cleared", 32'(rv[0]), 32'h0);
            end else begin
                fr = {$urandom, $urandom, $urandom, $urandom};
                if (kind == 2'b11 && !dat) dat_lvl = 4'hE;
                pulse_rsp(fr);
                model_rsp(kind, fr);
                rd(3'd2, rv); chk("R6 cmd inhibit cleared by response", 32'(rv[0]), 32'h0);
                chk_rsp_words(kind == 2'b01 ? "R7 long response words" : "R6 short response words");
                if (kind == 2'b11 && !dat) begin
                    repeat (2) @(negedge clk);
                    rd(3'd2, rv); chk("R8 dat held while busy", 32'(rv[1]), 32'h1);
                    dat_lvl = 4'hF;
                    @(negedge clk);
                    rd(3'd2, rv); chk("R8 dat released", 32'(rv[1]), 32'h0);
                end
            end
            if (dat) begin
                rd(3'd2, rv); chk("R9 dat held before transfer end", 32'(rv[1]), 32'h1);
                pulse_xfer();
                rd(3'd2, rv); chk("R9 dat released on transfer end", 32'(rv[1]), 32'h0);
            end
        end
        chk("R4 no spurious drop", 32'(cmd_drop_err), 32'h0);

        // R4: write while CMD inhibit set is dropped
        wr(3'd1, mk_cmd(6'd5, 1'b0, 1'b1, 1'b1, 2'b10));
        wr(3'd1, mk_cmd(6'd9, 1'b0, 1'b0, 1'b0, 2'b00));
        rd(3'd1, rv); chk("R4 command unchanged", rv, mk_cmd(6'd5, 1'b0, 1'b1, 1'b1, 2'b10));
        chk("R4 request index unchanged", 32'(eng_idx), 32'd5);
        chk("R4 sticky error port", 32'(cmd_drop_err), 32'h1);
        rd(3'd3, rv); chk("R4 sticky error register", rv, 32'h1);
        pulse_ack();
        pulse_rsp(128'h1234_5678_9ABC_DEF0_0F1E_2D3C_4B5A_6978);
        model_rsp(2'b10, 128'h1234_5678_9ABC_DEF0_0F1E_2D3C_4B5A_6978);
        chk_rsp_words("R6 short keeps upper words");
        chk("R4 error stays set", 32'(cmd_drop_err), 32'h1);

        // R4/R8: busy period blocks busy-only commands, not others
        dat_lvl = 4'hE;
        wr(3'd1, mk_cmd(6'd12, 1'b0, 1'b0, 1'b0, 2'b11));
        pulse_ack();
        pulse_rsp(128'hAAAA);
        model_rsp(2'b11, 128'hAAAA);
        rd(3'd2, rv); chk("R8 busy holds dat", rv[1:0], 32'h2);
        wr(3'd1, mk_cmd(6'd13, 1'b0, 1'b0, 1'b0, 2'b11));
        rd(3'd1, rv); chk("R4 busy-only dropped under dat", rv, mk_cmd(6'd12, 1'b0, 1'b0, 1'b0, 2'b11));
        rd(3'd2, rv); chk("R4 no cmd inhibit from drop", rv[1:0], 32'h2);
        wr(3'd1, mk_cmd(6'd7, 1'b0, 1'b0, 1'b0, 2'b10));
        rd(3'd2, rv); chk("R4 ordinary command accepted under dat", rv[1:0], 32'h3);
        chk("R4 ordinary request index", 32'(eng_idx), 32'd7);
        pulse_ack();
        pulse_rsp(128'h5555_0000);
        model_rsp(2'b10, 128'h5555_0000);
        rd(3'd2, rv); chk("R8 dat still busy", rv[1:0], 32'h2);
        chk_rsp_words("R6 response during busy");
        dat_lvl = 4'hF;
        @(negedge clk);
        rd(3'd2, rv); chk("R8 busy ends", rv[1:0], 32'h0);

        // R10: timeout after ack on a data command
        wr(3'd1, mk_cmd(6'd17, 1'b1, 1'b0, 1'b0, 2'b01));
        pulse_ack();
        pulse_tmo();
        rd(3'd2, rv); chk("R10 timeout clears both", rv[1:0], 32'h0);
        chk_rsp_words("R10 responses unchanged");
        // R10: timeout before ack drops request; foreign DAT owner untouched
        dat_lvl = 4'hE;
        wr(3'd1, mk_cmd(6'd20, 1'b0, 1'b0, 1'b0, 2'b11));
        pulse_ack();
        pulse_rsp(128'hF00D_0000);
        model_rsp(2'b11, 128'hF00D_0000);
        wr(3'd1, mk_cmd(6'd21, 1'b0, 1'b0, 1'b0, 2'b10));
        pulse_tmo();
        chk("R10 request dropped", 32'(eng_req), 32'h0);
        rd(3'd2, rv); chk("R10 other owner dat kept", rv[1:0], 32'h2);
        chk_rsp_words("R10 responses unchanged");
        dat_lvl = 4'hF;
        @(negedge clk);
        rd(3'd2, rv); chk("R8 busy ends after timeout", rv[1:0], 32'h0);

        finish_run();
    end
endmodule